// File: doc/BRIEF.md
# ISA Secondary Strobe Decoder

This block sits next to the main ISA command sequencer. It turns the current bus cycle type and address into the secondary strobes that the bus and its side devices need. Two strobes are limited to the low megabyte: a system-memory read and a system-memory write. Three strobes go to a real-time-clock chip on its index and data ports. One chip select is shared between the boot ROM and the RTC, and its meaning depends on the cycle type. The block also produces the DMA address-enable flag. It filters the incoming 16-bit memory chip-select so that the flag is only seen during real memory cycles.

Every output comes from a single register stage. Each output therefore reflects the cycle type and address sampled at the previous rising clock edge. The 16-bit I/O chip-select line is never driven by this block. As a result, accesses to registers inside the chip run as 8-bit I/O cycles. The asynchronous reset is synchronised on release. While it is active, every strobe is inactive.

Top module: `isa_strobe_decoder`

## Requirements
- R1: `smemr_no` goes low for a memory read (`cyc_kind_i`=1) whose 24-bit address is below 0x100000, and for every refresh cycle (`cyc_kind_i`=5) whatever the address. In all other cases it is high.
- R2: `smemw_no` goes low only for a memory write (`cyc_kind_i`=2) below 0x100000. It stays high during refresh and for every other cycle kind.
- R3: `rtc_as_o` (active-high) is 1 only for an I/O write (`cyc_kind_i`=4) to port 0x0070.
- R4: `rtc_wr_no` goes low only for an I/O write to port 0x0071.
- R5: `rtc_rd_no` goes low only for an I/O read (`cyc_kind_i`=3) from port 0x0071.
- R6: During a memory read or write, `romrtc_cs_no` goes low when the address lies in 0x0F0000–0x0FFFFF or in its alias 0xFF0000–0xFFFFFF. It is high for any other memory address and during refresh.
- R7: During an I/O read or write, `romrtc_cs_no` goes low when the port is 0x0070 or 0x0071. The comparison uses all 16 bits of `addr_i[15:0]`, so 0x0170 does not hit. Bits 23:16 play no part in an I/O cycle.
- R8: `mcs16_q_no` follows `mcs16_n_i` during memory read and write cycles. It is forced high during I/O, refresh and idle (`cyc_kind_i`=0) cycles.
- R9: `aen_o` equals `dma_own_i`, registered, whatever the cycle kind.
- R10: `iocs16_oe_o` is always 0.
- R11: Outputs appear one clock after the inputs are sampled. During reset, all active-low outputs are 1, and `rtc_as_o` and `aen_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cyc_kind_i | input | 3 | Cycle kind: 0 idle, 1 mem read, 2 mem write, 3 I/O read, 4 I/O write, 5 refresh |
| addr_i | input | 24 | Memory address, or I/O port in bits 15:0 |
| dma_own_i | input | 1 | DMA controller owns the bus |
| mcs16_n_i | input | 1 | Raw 16-bit memory chip-select, active low |
| smemr_no | output | 1 | Low-megabyte memory read strobe |
| smemw_no | output | 1 | Low-megabyte memory write strobe |
| rtc_as_o | output | 1 | RTC address strobe, active high |
| rtc_wr_no | output | 1 | RTC data write strobe |
| rtc_rd_no | output | 1 | RTC data read strobe |
| romrtc_cs_no | output | 1 | Shared ROM / RTC chip select |
| mcs16_q_no | output | 1 | Qualified 16-bit memory chip-select |
| aen_o | output | 1 | DMA address enable |
| iocs16_oe_o | output | 1 | Output enable for the 16-bit I/O chip-select, held off |

## Verification
Two functions can fall in the same cycle. The first pair is the DMA address enable and a memory strobe: a DMA-owned write below one megabyte must give `aen_o` high and `smemw_no` low together. The second pair is the shared chip select and an RTC strobe on the same I/O cycle. The bench provokes both by driving cycles that meet several conditions at once. Its scoreboard predicts every output field from the requirements alone and compares the whole set one clock later. A refresh aimed at the ROM alias and an I/O read with nonzero high address bits test how each function's qualification keeps it apart from the others.

// File: rtl/isa_dec_pkg.sv
package isa_dec_pkg;

  typedef enum logic [2:0] {
    CYC_IDLE = 3'd0,
    CYC_MRD  = 3'd1,
    CYC_MWR  = 3'd2,
    CYC_IORD = 3'd3,
    CYC_IOWR = 3'd4,
    CYC_REF  = 3'd5
  } cyc_kind_e;

  // Registered strobe bundle; active-low fields end in _n.
  typedef struct packed {
    logic smemr_n;
    logic smemw_n;
    logic rtc_as;
    logic rtc_wr_n;
    logic rtc_rd_n;
    logic romrtc_cs_n;
    logic mcs16_q_n;
    logic aen;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{
    smemr_n:     1'b1,
    smemw_n:     1'b1,
    rtc_as:      1'b0,
    rtc_wr_n:    1'b1,
    rtc_rd_n:    1'b1,
    romrtc_cs_n: 1'b1,
    mcs16_q_n:   1'b1,
    aen:         1'b0
  };

endpackage

// File: rtl/isa_mem_region_decode.sv
// Classifies a memory address: low megabyte and boot ROM window.
module isa_mem_region_decode #(
  parameter int unsigned     ADDR_W    = 24,
  parameter int unsigned     LOWMEM_W  = 20,
  parameter int unsigned     ROM_SEG_W = 4,
  parameter logic [3:0]      ROM_SEG   = 4'hF,
  parameter bit              ROM_ALIAS = 1'b1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              low_meg_o,
  output logic              rom_hit_o
);

  localparam int unsigned HI_W = ADDR_W - LOWMEM_W;

  logic [HI_W-1:0]      hi_bits;
  logic [ROM_SEG_W-1:0] seg_bits;
  logic                 seg_match;
  logic                 page_ok;

  assign hi_bits   = addr_i[ADDR_W-1:LOWMEM_W];
  assign seg_bits  = addr_i[LOWMEM_W-1:LOWMEM_W-ROM_SEG_W];
  assign low_meg_o = (hi_bits == '0);
  assign seg_match = (seg_bits == ROM_SEG[ROM_SEG_W-1:0]);

  generate
    if (ROM_ALIAS) begin : g_alias
      assign page_ok = (hi_bits == '0) || (&hi_bits);
    end else begin : g_no_alias
      assign page_ok = (hi_bits == '0);
    end
  endgenerate

  assign rom_hit_o = seg_match && page_ok;

endmodule

// File: rtl/isa_rtc_port_decode.sv
// Full-width compare of the I/O port against the two RTC ports.
module isa_rtc_port_decode #(
  parameter int unsigned      IO_W       = 16,
  parameter logic [15:0]      INDEX_PORT = 16'h0070,
  parameter logic [15:0]      DATA_PORT  = 16'h0071
) (
  input  logic [IO_W-1:0] port_i,
  output logic            index_hit_o,
  output logic            data_hit_o
);

  assign index_hit_o = (port_i == INDEX_PORT[IO_W-1:0]);
  assign data_hit_o  = (port_i == DATA_PORT[IO_W-1:0]);

endmodule

// File: rtl/isa_strobe_reg.sv
// Output register stage for the strobe bundle.
module isa_strobe_reg
  import isa_dec_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    en_i,
  input  strobe_t d_i,
  output strobe_t q_o
);

  strobe_t q_next;

  always_comb begin
    q_next = q_o;
    if (en_i) begin
      q_next = d_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= STROBE_IDLE;
    end else begin
      q_o <= q_next;
    end
  end

endmodule

// File: rtl/isa_strobe_decoder.sv
module isa_strobe_decoder
  import isa_dec_pkg::*;
#(
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned IO_W       = 16,
  parameter int unsigned LOWMEM_W   = 20,
  parameter int unsigned ROM_SEG_W  = 4,
  parameter logic [3:0]  ROM_SEG    = 4'hF,
  parameter bit          ROM_ALIAS  = 1'b1,
  parameter logic [15:0] INDEX_PORT = 16'h0070,
  parameter logic [15:0] DATA_PORT  = 16'h0071,
  parameter int unsigned RST_SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        cyc_kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              dma_own_i,
  input  logic              mcs16_n_i,
  output logic              smemr_no,
  output logic              smemw_no,
  output logic              rtc_as_o,
  output logic              rtc_wr_no,
  output logic              rtc_rd_no,
  output logic              romrtc_cs_no,
  output logic              mcs16_q_no,
  output logic              aen_o,
  output logic              iocs16_oe_o
);

  // Reset: asserted asynchronously, released on the clock.
  logic [RST_SYNC_N-1:0] rst_pipe;
  logic                  rst_sync_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[RST_SYNC_N-2:0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe[RST_SYNC_N-1];

  // Cycle classification.
  cyc_kind_e kind;
  logic      is_mrd, is_mwr, is_iord, is_iowr, is_ref;
  logic      mem_cyc, io_cyc;

  assign kind    = cyc_kind_e'(cyc_kind_i);
  assign is_mrd  = (kind == CYC_MRD);
  assign is_mwr  = (kind == CYC_MWR);
  assign is_iord = (kind == CYC_IORD);
  assign is_iowr = (kind == CYC_IOWR);
  assign is_ref  = (kind == CYC_REF);
  assign mem_cyc = is_mrd || is_mwr;
  assign io_cyc  = is_iord || is_iowr;

  // Address decoders.
  logic low_meg, rom_hit, idx_hit, dat_hit;

  isa_mem_region_decode #(
    .ADDR_W    (ADDR_W),
    .LOWMEM_W  (LOWMEM_W),
    .ROM_SEG_W (ROM_SEG_W),
    .ROM_SEG   (ROM_SEG),
    .ROM_ALIAS (ROM_ALIAS)
  ) u_mem_dec (
    .addr_i    (addr_i),
    .low_meg_o (low_meg),
    .rom_hit_o (rom_hit)
  );

  isa_rtc_port_decode #(
    .IO_W       (IO_W),
    .INDEX_PORT (INDEX_PORT),
    .DATA_PORT  (DATA_PORT)
  ) u_rtc_dec (
    .port_i      (addr_i[IO_W-1:0]),
    .index_hit_o (idx_hit),
    .data_hit_o  (dat_hit)
  );

  // Next-state strobe bundle.
  strobe_t nxt;
  strobe_t cur;

  always_comb begin
    nxt             = STROBE_IDLE;
    nxt.smemr_n     = !((is_mrd && low_meg) || is_ref);
    nxt.smemw_n     = !(is_mwr && low_meg);
    nxt.rtc_as      = is_iowr && idx_hit;
    nxt.rtc_wr_n    = !(is_iowr && dat_hit);
    nxt.rtc_rd_n    = !(is_iord && dat_hit);
    nxt.romrtc_cs_n = !((mem_cyc && rom_hit) || (io_cyc && (idx_hit || dat_hit)));
    nxt.mcs16_q_n   = mem_cyc ? mcs16_n_i : 1'b1;
    nxt.aen         = dma_own_i;
  end

  isa_strobe_reg u_out_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .en_i   (1'b1),
    .d_i    (nxt),
    .q_o    (cur)
  );

  assign smemr_no     = cur.smemr_n;
  assign smemw_no     = cur.smemw_n;
  assign rtc_as_o     = cur.rtc_as;
  assign rtc_wr_no    = cur.rtc_wr_n;
  assign rtc_rd_no    = cur.rtc_rd_n;
  assign romrtc_cs_no = cur.romrtc_cs_n;
  assign mcs16_q_no   = cur.mcs16_q_n;
  assign aen_o        = cur.aen;
  assign iocs16_oe_o  = 1'b0;

endmodule

// File: rtl/isa_strobe_decoder_chk.sv
module isa_strobe_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  cyc_kind,
  input logic [15:0] port,
  input logic        dma_own,
  input logic        smemr_n,
  input logic        smemw_n,
  input logic        rtc_as,
  input logic        rtc_wr_n,
  input logic        rtc_rd_n,
  input logic        mcs16_q_n,
  input logic        aen
);

  // Set one clock after reset release so $past never reaches into reset.
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
    end else begin
      armed <= 1'b1;
    end
  end

  // R1
  refresh_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(cyc_kind) == 3'd5) |-> !smemr_n);

  // R2
  refresh_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(cyc_kind) == 3'd5) |-> smemw_n);

  // R3
  rtc_as_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && rtc_as) |-> ($past(cyc_kind) == 3'd4 && $past(port) == 16'h0070));

  // R4
  rtc_wr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !rtc_wr_n) |-> ($past(cyc_kind) == 3'd4 && $past(port) == 16'h0071));

  // R5
  rtc_rd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !rtc_rd_n) |-> ($past(cyc_kind) == 3'd3 && $past(port) == 16'h0071));

  // R3
  rtc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rtc_as, !rtc_wr_n, !rtc_rd_n}));

  // R8
  mcs16_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(cyc_kind) != 3'd1 && $past(cyc_kind) != 3'd2) |-> mcs16_q_n);

  // R9
  aen_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (aen == $past(dma_own)));

endmodule

bind isa_strobe_decoder isa_strobe_decoder_chk u_chk (
  .clk       (clk_i),
  .rst_n     (rst_sync_n),
  .cyc_kind  (cyc_kind_i),
  .port      (addr_i[15:0]),
  .dma_own   (dma_own_i),
  .smemr_n   (smemr_no),
  .smemw_n   (smemw_no),
  .rtc_as    (rtc_as_o),
  .rtc_wr_n  (rtc_wr_no),
  .rtc_rd_n  (rtc_rd_no),
  .mcs16_q_n (mcs16_q_no),
  .aen       (aen_o)
);

// File: tb/test_isa_strobe_decoder.sv
`timescale 1ns/100ps
module test_isa_strobe_decoder;

  logic        clk;
  logic        rst_n;
  logic [2:0]  kind;
  logic [23:0] addr;
  logic        dma;
  logic        mcs;
  logic smemr_n, smemw_n, rtc_as, rtc_wr_n, rtc_rd_n, cs_n, mq_n, aen, oe;

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct packed {
    logic smemr_n, smemw_n, rtc_as, rtc_wr_n, rtc_rd_n, cs_n, mq_n, aen;
  } exp_t;

  exp_t sb_q[$];

  isa_strobe_decoder i_isa_strobe_decoder (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .cyc_kind_i   (kind),
    .addr_i       (addr),
    .dma_own_i    (dma),
    .mcs16_n_i    (mcs),
    .smemr_no     (smemr_n),
    .smemw_no     (smemw_n),
    .rtc_as_o     (rtc_as),
    .rtc_wr_no    (rtc_wr_n),
    .rtc_rd_no    (rtc_rd_n),
    .romrtc_cs_no (cs_n),
    .mcs16_q_no   (mq_n),
    .aen_o        (aen),
    .iocs16_oe_o  (oe)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input logic act, input logic exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Reference model derived from the requirements.
  function automatic exp_t model(input logic [2:0] k, input logic [23:0] a,
                                 input logic d, input logic m);
    exp_t  e;
    logic  lo, rom, memc, ioc;
    logic [15:0] p;
    lo   = (a[23:20] == 4'h0);
    rom  = (a[19:16] == 4'hF) && (a[23:20] == 4'h0 || a[23:20] == 4'hF);
    p    = a[15:0];
    memc = (k == 3'd1) || (k == 3'd2);
    ioc  = (k == 3'd3) || (k == 3'd4);
    e.smemr_n  = !((k == 3'd1 && lo) || k == 3'd5);
    e.smemw_n  = !(k == 3'd2 && lo);
    e.rtc_as   = (k == 3'd4) && (p == 16'h0070);
    e.rtc_wr_n = !((k == 3'd4) && (p == 16'h0071));
    e.rtc_rd_n = !((k == 3'd3) && (p == 16'h0071));
    e.cs_n     = !((memc && rom) || (ioc && (p == 16'h0070 || p == 16'h0071)));
    e.mq_n     = memc ? m : 1'b1;
    e.aen      = d;
    return e;
  endfunction

  task automatic drive(input logic [2:0] k, input logic [23:0] a,
                       input logic d, input logic m);
    @(negedge clk);
    kind = k; addr = a; dma = d; mcs = m;
    sb_q.push_back(model(k, a, d, m));
  endtask

  // Monitor: compares one clock after each drive.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        chk(smemr_n,  e.smemr_n,  "R1 smemr");
        chk(smemw_n,  e.smemw_n,  "R2 smemw");
        chk(rtc_as,   e.rtc_as,   "R3 rtc_as");
        chk(rtc_wr_n, e.rtc_wr_n, "R4 rtc_wr");
        chk(rtc_rd_n, e.rtc_rd_n, "R5 rtc_rd");
        chk(cs_n,     e.cs_n,     "R6/R7 romrtc_cs");
        chk(mq_n,     e.mq_n,     "R8 mcs16_q");
        chk(aen,      e.aen,      "R9 aen");
        chk(oe,       1'b0,       "R10 iocs16_oe");
      end
    end
  end

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; kind = 3'd0; addr = '0; dma = 1'b1; mcs = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(smemr_n, 1'b1, "R11 reset smemr");
    chk(smemw_n, 1'b1, "R11 reset smemw");
    chk(rtc_as,  1'b0, "R11 reset rtc_as");
    chk(cs_n,    1'b1, "R11 reset cs");
    chk(mq_n,    1'b1, "R11 reset mcs16_q");
    chk(aen,     1'b0, "R11 reset aen");
    dma = 1'b0; mcs = 1'b1;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    drive(3'd0, 24'h000000, 1'b0, 1'b1);            // idle
    drive(3'd5, 24'hFF1234, 1'b0, 1'b0);            // R1 R2 R6 R8 refresh at ROM alias
    drive(3'd1, 24'h0F1234, 1'b0, 1'b0);            // R1 R6 R8
    drive(3'd1, 24'hFF8000, 1'b0, 1'b1);            // R6 alias, R1 above 1 MB
    drive(3'd1, 24'h100000, 1'b0, 1'b0);            // R1 boundary
    drive(3'd1, 24'h0FFFFF, 1'b0, 1'b1);            // R1 R6 top of low MB
    drive(3'd1, 24'h0EFFFF, 1'b0, 1'b1);            // R6 just below ROM
    drive(3'd2, 24'h0A0000, 1'b0, 1'b1);            // R2
    drive(3'd2, 24'h200000, 1'b0, 1'b0);            // R2 above 1 MB
    drive(3'd2, 24'h0B0000, 1'b1, 1'b0);            // R9 with R2 same cycle
    drive(3'd4, 24'h000070, 1'b0, 1'b0);            // R3 R7 R8
    drive(3'd4, 24'h000071, 1'b0, 1'b1);            // R4 R7
    drive(3'd3, 24'h000071, 1'b1, 1'b0);            // R5 R7 R9
    drive(3'd3, 24'h000070, 1'b0, 1'b1);            // R7 read index
    drive(3'd4, 24'h000170, 1'b0, 1'b1);            // R7 no partial alias
    drive(3'd3, 24'hAB0071, 1'b0, 1'b1);            // R5 R7 high bits ignored
    drive(3'd3, 24'h000072, 1'b0, 1'b1);            // R7 miss
    drive(3'd0, 24'h0F0000, 1'b1, 1'b0);            // R8 idle gate, R6 idle
    drive(3'd0, 24'h000000, 1'b0, 1'b1);

    // R11 one-clock latency
    @(negedge clk);
    kind = 3'd4; addr = 24'h000070; dma = 1'b0; mcs = 1'b1;
    sb_q.push_back(model(3'd4, 24'h000070, 1'b0, 1'b1));
    #1;
    chk(rtc_as, 1'b0, "R11 latency before edge");
    drive(3'd0, 24'h000000, 1'b0, 1'b1);

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule